// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed serial memory. A fast system clock oversamples the two-wire bus lines. The block finds the bus conditions and decodes the device select byte against three strap inputs. It then gathers a two-byte location and runs the write, current-location read, random read and sequential read transactions. It never drives the data line high: it only asserts an open-drain pull-down enable.

Toward the storage side it has two paths. A combinational read port is addressed by the shared location counter. A single-cycle write request carries a location and a byte to a page-buffer or array controller. That controller reports a running internal write through a busy input. While busy is high the engine declines to answer its device select, so a bus master can poll until the write has finished.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling data line while the clock is high is a START and always restarts device selection. A rising data line while the clock is high is a STOP and returns the engine to idle. After a STOP, bytes clocked without a new START get no acknowledge.
- R2: The select byte is matched MSB first as `1010`, then the three strap bits (dev_sel[2] first), then the direction bit (1 = read). On a match the engine pulls the line low during the ninth clock. On a mismatch it answers nothing, and it ignores all later bytes until the next START.
- R3: While busy_i is high, a matching select byte is not acknowledged.
- R4: In write direction, two location bytes follow, high byte first, and each is acknowledged. Only the low ADDR_W-8 bits of the high byte are used; its upper bits are ignored.
- R5: Each data byte after the location bytes is acknowledged and produces a one-cycle wr_req with wr_addr and wr_data.
- R6: Consecutive data bytes in one write advance only the low PAGE_BITS bits of the location, wrapping inside the page. The upper bits stay fixed.
- R7: After any access to location N, rd_addr holds N+1 (or its page-wrapped successor after a write). A read started without a location phase returns the byte at that counter.
- R8: A location phase followed by a repeated START and a read select returns the byte at the newly loaded location.
- R9: During a read, a master acknowledge after a byte causes the next location's byte to be sent. A master non-acknowledge makes the engine release the line until the next START or STOP.
- R10: The read counter spans the whole array and wraps from 2^ADDR_W-1 to 0.
- R11: sda_oe changes only while the clock line is low.
- R12: After reset, sda_oe and wr_req are low and rd_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull-down enable for the data line (1 = drive low) |
| dev_sel | input | 3 | Device select strap bits, held static |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_addr | output | ADDR_W | Location counter, addresses the read port |
| rd_data | input | 8 | Byte at rd_addr |
| wr_req | output | 1 | One-cycle write request |
| wr_addr | output | ADDR_W | Location for the write request |
| wr_data | output | 8 | Byte for the write request |

## Verification
Most internal faults show up on the bus within the byte where they occur. A wrong bit count or a wrong byte-kind state makes the ninth-clock acknowledge appear or vanish on the spot. A broken shift register corrupts the byte returned in the same read. A corrupt location counter is less direct: it shows on rd_addr right away, but in bus data only at the next read byte, so each write is followed by a current-location read. Page and array wrap faults are exposed by walking across a page edge and across the top of the array.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK,
      ST_WAIT
   } eng_state_t;

   typedef enum logic [1:0] {
      K_DEV,
      K_AHI,
      K_ALO,
      K_DATA
   } byte_kind_t;

   localparam logic [3:0] DEV_NIBBLE = 4'b1010;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
   parameter int LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], d};
   end

   generate
      if (LEN == 0) begin : g_bypass
         assign q = sync_q[1];
      end else begin : g_debounce
         logic [LEN-1:0] hist_q;
         logic [LEN:0]   hist_n;
         logic           q_r;
         assign hist_n = {hist_q, sync_q[1]};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '1;
               q_r    <= 1'b1;
            end else begin
               hist_q <= hist_n[LEN-1:0];
               if (&hist_q)       q_r <= 1'b1;
               else if (~|hist_q) q_r <= 1'b0;
            end
         end
         assign q = q_r;
      end
   endgenerate
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise = !scl_q && scl_f;
   assign scl_fall = scl_q && !scl_f;
   // R1: data edges while the clock stays high are bus conditions
   assign start_c  = scl_q && scl_f && sda_q && !sda_f;
   assign stop_c   = scl_q && scl_f && !sda_q && sda_f;
endmodule

// File: rtl/i2c_mem_fsm.sv
module i2c_mem_fsm
   import i2c_mem_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int PAGE_BITS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_c,
   input  logic              stop_c,
   input  logic [2:0]        dev_sel,
   input  logic              busy_i,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              sda_oe,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);
   localparam int HI_W = ADDR_W - 8;

   eng_state_t        st;
   byte_kind_t        kind;
   logic [7:0]        shreg;
   logic [2:0]        bitc;
   logic              full, ack_dev, rw_q, macked, oe_q;
   logic [HI_W-1:0]   hi_q;
   logic [ADDR_W-1:0] ptr;
   logic [PAGE_BITS-1:0] pg_lo;
   logic [ADDR_W-1:0] page_next;
   logic              dev_hit, load_byte;

   assign pg_lo     = ptr[PAGE_BITS-1:0] + 1'b1;
   assign page_next = {ptr[ADDR_W-1:PAGE_BITS], pg_lo};
   assign dev_hit   = (shreg[7:1] == {DEV_NIBBLE, dev_sel});
   assign load_byte = scl_fall &&
                      ((st == ST_ACK && ack_dev && rw_q) ||
                       (st == ST_TXACK && macked));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; kind <= K_DEV; shreg <= '0; bitc <= '0;
         full <= 1'b0; ack_dev <= 1'b0; rw_q <= 1'b0; macked <= 1'b0;
         oe_q <= 1'b0; hi_q <= '0; ptr <= '0;
         wr_req <= 1'b0; wr_addr <= '0; wr_data <= '0;
      end else begin
         wr_req <= 1'b0;
         if (start_c) begin
            st <= ST_RX; kind <= K_DEV; bitc <= '0; full <= 1'b0; oe_q <= 1'b0;
         end else if (stop_c) begin
            st <= ST_IDLE; oe_q <= 1'b0;
         end else if (load_byte) begin
            shreg <= rd_data;
            oe_q  <= ~rd_data[7];
            ptr   <= ptr + 1'b1;
            bitc  <= '0;
            st    <= ST_TX;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda_f};
                     bitc  <= bitc + 1'b1;
                     full  <= (bitc == 3'd7);
                  end else if (scl_fall && full) begin
                     full    <= 1'b0;
                     st      <= ST_ACK;
                     oe_q    <= 1'b1;
                     ack_dev <= (kind == K_DEV);
                     case (kind)
                        K_DEV: begin
                           if (dev_hit && !busy_i) begin
                              rw_q <= shreg[0];
                              kind <= K_AHI;
                           end else begin
                              st   <= ST_IDLE;
                              oe_q <= 1'b0;
                           end
                        end
                        K_AHI: begin
                           hi_q <= shreg[HI_W-1:0];
                           kind <= K_ALO;
                        end
                        K_ALO: begin
                           ptr  <= {hi_q, shreg};
                           kind <= K_DATA;
                        end
                        default: begin
                           wr_req  <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= shreg;
                           ptr     <= page_next;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     oe_q <= 1'b0;
                     bitc <= '0;
                     st   <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     bitc <= bitc + 1'b1;
                     if (bitc == 3'd7) begin
                        oe_q <= 1'b0;
                        st   <= ST_TXACK;
                     end else begin
                        oe_q  <= ~shreg[6];
                        shreg <= {shreg[6:0], 1'b0};
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise)      macked <= ~sda_f;
                  else if (scl_fall) st     <= ST_WAIT;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe  = oe_q;
   assign rd_addr = ptr;

   // R11
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_f);
   // R3
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACK && ack_dev && $rose(sda_oe)) |-> !$past(busy_i));
   // R2
   dev_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACK && ack_dev && sda_oe) |-> (shreg[7:1] == {DEV_NIBBLE, dev_sel}));
   // R5
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> !wr_req);
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
   parameter int ADDR_W    = 13,
   parameter int PAGE_BITS = 6,
   parameter int FILT_LEN  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [2:0]        dev_sel,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);
   localparam int N_LINES = 2;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
         $fatal(1, "ADDR_W must lie in 9..16");
      end
      if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_pg
         $fatal(1, "PAGE_BITS must lie in 1..ADDR_W-1");
      end
      if (FILT_LEN < 0 || FILT_LEN > 8) begin : g_bad_flt
         $fatal(1, "FILT_LEN must lie in 0..8");
      end
   endgenerate

   logic [N_LINES-1:0] raw_l, flt_l;
   logic scl_rise, scl_fall, start_c, stop_c;

   assign raw_l = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_line
         i2c_glitch_filter #(.LEN(FILT_LEN)) u_flt (
            .clk(clk), .rst_n(rst_n), .d(raw_l[g]), .q(flt_l[g]));
      end
   endgenerate

   i2c_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_f(flt_l[0]), .sda_f(flt_l[1]),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c));

   i2c_mem_fsm #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_f(flt_l[0]), .sda_f(flt_l[1]),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c),
      .dev_sel(dev_sel), .busy_i(busy_i), .rd_data(rd_data),
      .rd_addr(rd_addr), .sda_oe(sda_oe), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_data(wr_data));
endmodule

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
   localparam int AW = 13;
   localparam int H  = 20;
   localparam int Q  = 10;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
   logic sda_oe, wr_req;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [7:0] rd_data, wr_data;
   wire sda_line = sda_m & ~sda_oe;

   int n_chk = 0, n_err = 0, cyc = 0, oe_bad = 0;
   logic [AW-1:0] wl_a [0:15];
   logic [7:0]    wl_d [0:15];
   int wn = 0;
   logic prev_oe = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [7:0] model(input logic [AW-1:0] a);
      return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
   endfunction
   assign rd_data = model(rd_addr);

   i2c_mem_slave u_i2c_mem_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .dev_sel(STRAP), .busy_i(busy),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_data(wr_data));

   always @(negedge clk) begin
      if (wr_req) begin
         wl_a[wn[3:0]] <= wr_addr;
         wl_d[wn[3:0]] <= wr_data;
         wn <= wn + 1;
      end
      if (rst_n && scl_m && sda_oe != prev_oe) oe_bad <= oe_bad + 1;
      prev_oe <= sda_oe;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bstart();
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H); scl_m = 1'b0;
   endtask

   task automatic bstop();
      tick(Q); sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         tick(Q); sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0;
      end
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      ack = ~sda_line; tick(Q); scl_m = 1'b0;
   endtask

   task automatic rbyte(input logic mack, output logic [7:0] b);
      b = '0;
      for (int i = 0; i < 8; i++) begin
         tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
         b = {b[6:0], sda_line}; tick(Q); scl_m = 1'b0;
      end
      tick(Q); sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0;
   endtask

   task automatic set_loc(input logic [7:0] hi, input logic [7:0] lo);
      logic a;
      bstart();
      wbyte(DEVW, a); check("R2 select write", a, 1);
      wbyte(hi, a);   check("R4 high byte ack", a, 1);
      wbyte(lo, a);   check("R4 low byte ack", a, 1);
   endtask

   initial begin
      logic a;
      logic [7:0] b;
      int w0;
      tick(5);
      check("R12 sda_oe at reset", sda_oe, 0);
      check("R12 wr_req at reset", wr_req, 0);
      check("R12 rd_addr at reset", rd_addr, 0);
      rst_n = 1'b1;
      tick(10);

      // R2: sweep every strap value in the select byte
      for (int s = 0; s < 8; s++) begin
         bstart();
         wbyte({4'b1010, 3'(s), 1'b0}, a);
         check("R2 strap sweep", a, (s == int'(STRAP)) ? 1 : 0);
         bstop();
      end
      bstart(); wbyte({4'b1011, STRAP, 1'b0}, a); check("R2 wrong nibble", a, 0); bstop();

      // R2: after a mismatch later bytes are ignored
      w0 = wn;
      bstart(); wbyte({4'b1010, ~STRAP, 1'b0}, a); check("R2 mismatch nack", a, 0);
      wbyte(8'h12, a); check("R2 ignored byte", a, 0);
      wbyte(8'h34, a); check("R2 ignored byte", a, 0);
      wbyte(8'h56, a); check("R2 ignored byte", a, 0);
      bstop();
      check("R2 no write after mismatch", wn - w0, 0);

      // R3: busy blocks the select acknowledge
      busy = 1'b1;
      bstart(); wbyte(DEVW, a); check("R3 busy nack", a, 0); bstop();
      busy = 1'b0;
      bstart(); wbyte(DEVW, a); check("R3 ack after busy clears", a, 1); bstop();

      // R4 R5: byte write with don't-care upper location bits
      w0 = wn;
      set_loc(8'hE4, 8'h56);
      wbyte(8'hA7, a); check("R5 data ack", a, 1);
      bstop();
      check("R5 write count", wn - w0, 1);
      check("R4 write location", wl_a[w0[3:0]], 13'h0456);
      check("R5 write data", wl_d[w0[3:0]], 8'hA7);
      check("R7 counter after write", rd_addr, 13'h0457);

      // R7: current location read
      bstart(); wbyte(DEVR, a); check("R7 select read", a, 1);
      rbyte(1'b0, b); check("R7 current read data", b, model(13'h0457));
      bstop();
      check("R7 counter after read", rd_addr, 13'h0458);

      // R6: page write wraps inside the page
      w0 = wn;
      set_loc(8'h01, 8'h3E);
      for (int k = 0; k < 4; k++) begin
         wbyte(8'hC0 + 8'(k), a); check("R6 page data ack", a, 1);
      end
      bstop();
      check("R6 page write count", wn - w0, 4);
      for (int k = 0; k < 4; k++) begin
         check("R6 page location", wl_a[4'(w0 + k)], 13'h0100 + ((13'h3E + k) % 64));
         check("R6 page data", wl_d[4'(w0 + k)], 8'hC0 + k);
      end

      // R8 R9: random then sequential read
      set_loc(8'h12, 8'h34);
      bstart(); wbyte(DEVR, a); check("R8 repeated start select", a, 1);
      for (int k = 0; k < 4; k++) begin
         rbyte(k < 3, b);
         check("R9 sequential data", b, model(13'h1234 + 13'(k)));
      end
      // R9: after the NACK the line stays released
      rbyte(1'b0, b); check("R9 line released after nack", b, 8'hFF);
      bstop();

      // R10: counter wraps at the top of the array
      set_loc(8'h1F, 8'hFE);
      bstart(); wbyte(DEVR, a); check("R8 select read", a, 1);
      for (int k = 0; k < 4; k++) begin
         rbyte(k < 3, b);
         check("R10 wrap data", b, model(13'(13'h1FFE + k)));
      end
      bstop();

      // R1: STOP mid-transaction then a byte without START
      bstart(); wbyte(DEVW, a); check("R1 select", a, 1);
      wbyte(8'h00, a); bstop();
      wbyte(DEVW, a); check("R1 no ack without START", a, 0);
      bstop();
      bstart(); wbyte(DEVW, a); check("R1 START restarts", a, 1); bstop();

      check("R11 sda_oe changes while SCL high", oe_bad, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule